// File: doc/BRIEF.md
# Linked Descriptor DMA Channel Engine

This block is one direction of a descriptor-driven DMA channel. Software builds a singly linked chain of four-word descriptors in a small descriptor RAM inside the block, hands ownership of each descriptor to the engine through a flag in its mode word, and starts the chain by writing the address of its first descriptor to the head register. The engine walks the chain. For each owned descriptor it models the payload move as a count of one cycle per byte of the length field. It then writes status back into the mode word and follows the next pointer. After each completion it raises its interrupt level until the host acknowledges.

Software reaches the RAM and the registers through one host port. `host_space` low selects the RAM and high selects the registers. All pointers are word addresses into the RAM, and descriptors sit on four-word boundaries. Within a descriptor, word +0 is the next pointer (0 ends the chain), word +1 the buffer pointer, word +2 the buffer length and word +3 the mode word.

The mode word bits are:

| Bits | Meaning |
|------|---------|
| 31 | start of packet |
| 30 | end of packet |
| 29 | engine owns the descriptor |
| 28 | end of queue |
| 27 | teardown done |
| 26 | keep CRC |
| 10:0 | length |

The registers, selected by `host_addr[2:0]`, are:

| Index | Register |
|-------|----------|
| 0 | enable, bit 0 |
| 1 | soft reset |
| 2 | head pointer; reads back the current descriptor |
| 3 | completion pointer |
| 4 | teardown command |
| 5 | sticky error, bit 0 |

The sequencer has five states:

- IDLE goes to LOAD on a start. A start is a nonzero head write while enabled, or the enable being set while a head pointer is held. IDLE goes to TDOWN when a teardown is pending.
- LOAD reads the mode word. It goes to IDLE when the owner bit is clear, to WBACK when the length is 0, and to MOVE otherwise.
- MOVE counts bytes and goes to WBACK on the last one.
- WBACK writes status back. It goes to LOAD when the next pointer is nonzero and to IDLE when it is 0.
- TDOWN finishes a teardown and goes to IDLE.

From LOAD, MOVE or WBACK, a pending teardown sends the engine to TDOWN. A soft reset forces IDLE from any state.

Top module: `ldma_channel`

## Requirements
- R1: After reset, irq is low and the completion pointer, head pointer, error flag and soft-reset registers all read 0.
- R2: When the engine is enabled and IDLE, a head write begins processing the descriptor at that address. The descriptor layout is next +0, buffer +1, length +2, mode +3, and the length is taken from mode bits 10:0.
- R3: For an owned descriptor of length L, irq rises L+2 cycles after the head-write edge (L=0 gives 2 cycles). The completion pointer then reads the descriptor's address.
- R4: Writeback clears owner bit 29 and keeps every other mode bit. It sets end-of-queue bit 28 only when the next pointer is 0.
- R5: A nonzero next pointer is followed at once, so each descriptor completes its own L+2 cycles after the previous one. After the last descriptor the head register reads 0.
- R6: A descriptor whose owner bit is clear is not written, no completion is raised, and the engine returns to IDLE with the head register reading 0.
- R7: Writing the completion register with the value it holds clears irq. Any other value leaves irq set.
- R8: A head write while the engine is not IDLE is ignored. It sets the error flag, which stays set until a soft reset.
- R9: Writing CHAN_ID to the teardown register makes the completion pointer read 0xFFFFFFFC and raises irq 2 cycles after the write edge. In the same step the current descriptor gets bit 27 set and bit 29 cleared, and the head reads 0. Any other value is ignored. Writing 0xFFFFFFFC to the completion register acknowledges the teardown.
- R10: With enable at 0 a head write is held but not processed. Setting enable starts it on the next cycle, so completion comes L+3 cycles after the enable-write edge.
- R11: Writing 1 to the soft-reset register clears the head, completion pointer, pending irq and error flag. The register reads 1 in the cycle right after the write and 0 from then on.
- R12: After an end-of-queue stop, a fresh head write to a newly linked descriptor restarts the engine with the R3 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| host_we | input | 1 | host write strobe |
| host_space | input | 1 | 0 selects the descriptor RAM, 1 selects the registers |
| host_addr | input | ADDR_W | RAM word address, or register index in bits 2:0 |
| host_wdata | input | 32 | host write data |
| host_rdata | output | 32 | combinational read data for host_addr |
| irq | output | 1 | completion pending, not yet acknowledged |

## Verification
Every result is due a fixed number of cycles after the edge that registers its stimulus:

- a completion L+2 cycles after the head write
- L+3 cycles after an enable write
- a teardown completion 2 cycles after the command
- a soft-reset readback of 1 in the very next cycle

The driver notes the cycle count at each write edge and pushes the exact due cycle into a scoreboard. The monitor compares that due cycle with the cycle at which irq rises, sampling on the falling edge. Mode words, pointers and flags are read back only after the due cycle. Any irq rise that has no matching expectation counts as a miscompare.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MOVE,
        ST_WBACK,
        ST_TDOWN
    } seq_state_t;

    localparam int MODE_SOP = 31;
    localparam int MODE_EOP = 30;
    localparam int MODE_OWN = 29;
    localparam int MODE_EOQ = 28;
    localparam int MODE_TDC = 27;
    localparam int MODE_CRC = 26;
    localparam int LEN_BITS = 11;

    localparam int W_NEXT = 0;
    localparam int W_BUF  = 1;
    localparam int W_LEN  = 2;
    localparam int W_MODE = 3;

    localparam logic [31:0] TD_MAGIC = 32'hFFFF_FFFC;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_SRST  = 3'd1;
    localparam logic [2:0] REG_HEAD  = 3'd2;
    localparam logic [2:0] REG_COMPL = 3'd3;
    localparam logic [2:0] REG_TDOWN = 3'd4;
    localparam logic [2:0] REG_ERR   = 3'd5;

endpackage

// File: rtl/ldma_desc_ram.sv
module ldma_desc_ram #(
    parameter int WORDS = 64,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [31:0]   h_wdata,
    output logic [31:0]   h_rdata,
    input  logic          e_we,
    input  logic [AW-1:0] e_addr,
    input  logic [31:0]   e_wdata,
    input  logic [AW-1:0] m_addr,
    output logic [31:0]   m_rdata,
    input  logic [AW-1:0] n_addr,
    output logic [31:0]   n_rdata
);
    logic [31:0] mem [WORDS];

    // engine write is issued last so it wins a same-word collision
    always_ff @(posedge clk) begin
        if (h_we) mem[h_addr] <= h_wdata;
        if (e_we) mem[e_addr] <= e_wdata;
    end

    assign h_rdata = mem[h_addr];
    assign m_rdata = mem[m_addr];
    assign n_rdata = mem[n_addr];
endmodule

// File: rtl/ldma_beat_cnt.sv
module ldma_beat_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= val;
        else if (dec && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/ldma_seq.sv
module ldma_seq
    import ldma_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                head_wr,
    input  logic [31:0]         head_val,
    input  logic                td_cmd,
    input  logic                ack_wr,
    input  logic [31:0]         ack_val,
    input  logic                srst_wr,
    input  logic [31:0]         mode_rd,
    input  logic [31:0]         next_rd,
    input  logic                cnt_last,
    output logic                cnt_load,
    output logic                cnt_dec,
    output logic [LEN_BITS-1:0] cnt_val,
    output logic                eng_we,
    output logic [31:0]         eng_wdata,
    output logic [31:0]         cur_q,
    output logic [31:0]         cp_q,
    output logic                pend_q,
    output logic                err_q,
    output logic                srst_busy_q,
    output logic                td_req_q,
    output seq_state_t          st_q
);
    seq_state_t nxt;
    logic       start;

    assign start = en && (head_wr ? (head_val != '0) : (cur_q != '0));

    always_comb begin
        nxt = st_q;
        unique case (st_q)
            ST_IDLE:  if (td_req_q)                   nxt = ST_TDOWN;
                      else if (start)                 nxt = ST_LOAD;
            ST_LOAD:  if (td_req_q)                   nxt = ST_TDOWN;
                      else if (!mode_rd[MODE_OWN])    nxt = ST_IDLE;
                      else if (mode_rd[LEN_BITS-1:0] == '0) nxt = ST_WBACK;
                      else                            nxt = ST_MOVE;
            ST_MOVE:  if (td_req_q)                   nxt = ST_TDOWN;
                      else if (cnt_last)              nxt = ST_WBACK;
            ST_WBACK: if (td_req_q)                   nxt = ST_TDOWN;
                      else if (next_rd != '0)         nxt = ST_LOAD;
                      else                            nxt = ST_IDLE;
            ST_TDOWN:                                 nxt = ST_IDLE;
            default:                                  nxt = ST_IDLE;
        endcase
        if (srst_wr) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cp_q        <= '0;
            pend_q      <= 1'b0;
            err_q       <= 1'b0;
            td_req_q    <= 1'b0;
            srst_busy_q <= 1'b0;
        end else if (srst_wr) begin
            cur_q       <= '0;
            cp_q        <= '0;
            pend_q      <= 1'b0;
            err_q       <= 1'b0;
            td_req_q    <= 1'b0;
            srst_busy_q <= 1'b1;
        end else begin
            srst_busy_q <= 1'b0;
            td_req_q    <= td_cmd || (td_req_q && st_q != ST_TDOWN);
            if (head_wr) begin
                if (st_q == ST_IDLE) cur_q <= head_val;
                else                 err_q <= 1'b1;
            end
            if (ack_wr && ack_val == cp_q) pend_q <= 1'b0;
            if (st_q == ST_LOAD && nxt == ST_IDLE) cur_q <= '0;
            if (st_q == ST_WBACK) begin
                cp_q   <= cur_q;
                pend_q <= 1'b1;
                cur_q  <= next_rd;
            end
            if (st_q == ST_TDOWN) begin
                cp_q   <= TD_MAGIC;
                pend_q <= 1'b1;
                cur_q  <= '0;
            end
        end
    end

    always_comb begin
        eng_we    = 1'b0;
        eng_wdata = mode_rd;
        eng_wdata[MODE_OWN] = 1'b0;
        if (st_q == ST_WBACK) begin
            eng_we = 1'b1;
            if (next_rd == '0) eng_wdata[MODE_EOQ] = 1'b1;
        end else if (st_q == ST_TDOWN && cur_q != '0) begin
            eng_we = 1'b1;
            eng_wdata[MODE_TDC] = 1'b1;
        end
    end

    assign cnt_load = (st_q == ST_LOAD) && (nxt == ST_MOVE);
    assign cnt_dec  = (st_q == ST_MOVE);
    assign cnt_val  = mode_rd[LEN_BITS-1:0];
endmodule

// File: rtl/ldma_channel.sv
module ldma_channel
    import ldma_pkg::*;
#(
    parameter int RAM_WORDS = 64,
    parameter int CHAN_ID   = 2,
    parameter int ADDR_W    = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_space,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              irq
);
    logic [2:0]          reg_idx;
    logic                reg_we, ram_we;
    logic                head_wr, td_cmd, ack_wr, srst_wr;
    logic                en_q;
    logic [31:0]         ram_rdata, mode_rd, next_rd, eng_wdata;
    logic [31:0]         cur_q, cp_q;
    logic                pend_q, err_q, srst_busy, td_req_q, eng_we;
    logic                cnt_load, cnt_dec, cnt_last;
    logic [LEN_BITS-1:0] cnt_val;
    logic [ADDR_W-1:0]   mode_idx, next_idx;
    seq_state_t          st_q;

    assign reg_idx  = host_addr[2:0];
    assign reg_we   = host_we && host_space;
    assign ram_we   = host_we && !host_space;
    assign head_wr  = reg_we && reg_idx == REG_HEAD;
    assign ack_wr   = reg_we && reg_idx == REG_COMPL;
    assign td_cmd   = reg_we && reg_idx == REG_TDOWN && host_wdata == 32'(CHAN_ID);
    assign srst_wr  = reg_we && reg_idx == REG_SRST && host_wdata[0];

    assign next_idx = cur_q[ADDR_W-1:0] + ADDR_W'(W_NEXT);
    assign mode_idx = cur_q[ADDR_W-1:0] + ADDR_W'(W_MODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               en_q <= 1'b0;
        else if (reg_we && reg_idx == REG_CTRL)   en_q <= host_wdata[0];
    end

    ldma_desc_ram #(.WORDS(RAM_WORDS), .AW(ADDR_W)) ram_i (
        .clk(clk),
        .h_we(ram_we), .h_addr(host_addr), .h_wdata(host_wdata), .h_rdata(ram_rdata),
        .e_we(eng_we), .e_addr(mode_idx), .e_wdata(eng_wdata),
        .m_addr(mode_idx), .m_rdata(mode_rd),
        .n_addr(next_idx), .n_rdata(next_rd)
    );

    ldma_beat_cnt #(.W(LEN_BITS)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .dec(cnt_dec),
        .val(cnt_val), .last(cnt_last)
    );

    ldma_seq seq_i (
        .clk(clk), .rst_n(rst_n), .en(en_q),
        .head_wr(head_wr), .head_val(host_wdata),
        .td_cmd(td_cmd), .ack_wr(ack_wr), .ack_val(host_wdata),
        .srst_wr(srst_wr), .mode_rd(mode_rd), .next_rd(next_rd),
        .cnt_last(cnt_last), .cnt_load(cnt_load), .cnt_dec(cnt_dec), .cnt_val(cnt_val),
        .eng_we(eng_we), .eng_wdata(eng_wdata),
        .cur_q(cur_q), .cp_q(cp_q), .pend_q(pend_q), .err_q(err_q),
        .srst_busy_q(srst_busy), .td_req_q(td_req_q), .st_q(st_q)
    );

    always_comb begin
        host_rdata = '0;
        if (!host_space) begin
            host_rdata = ram_rdata;
        end else begin
            case (reg_idx)
                REG_CTRL:  host_rdata = {31'b0, en_q};
                REG_SRST:  host_rdata = {31'b0, srst_busy};
                REG_HEAD:  host_rdata = cur_q;
                REG_COMPL: host_rdata = cp_q;
                REG_ERR:   host_rdata = {31'b0, err_q};
                default:   host_rdata = '0;
            endcase
        end
    end

    assign irq = pend_q;
endmodule

// File: rtl/ldma_channel_chk.sv
module ldma_channel_chk
    import ldma_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        host_we,
    input logic        host_space,
    input logic [2:0]  reg_idx,
    input logic [31:0] cp_q,
    input logic        err_q,
    input logic        srst_busy,
    input logic        srst_wr,
    input logic        eng_we,
    input logic        td_req_q,
    input seq_state_t  st_q
);
    assert_irq_drop_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(host_we && host_space && (reg_idx == REG_COMPL || reg_idx == REG_SRST)));

    assert_magic_after_tdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_q == TD_MAGIC && !$stable(cp_q)) |-> $past(st_q == ST_TDOWN));

    assert_tdown_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TDOWN) |-> $past(td_req_q));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !srst_wr) |=> err_q);

    assert_no_write_outside_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_LOAD || st_q == ST_MOVE) |-> !eng_we);

    assert_srst_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_busy && !srst_wr) |=> !srst_busy);

    assert_irq_has_pointer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cp_q != '0);
endmodule

bind ldma_channel ldma_channel_chk chk_i (
    .clk(clk), .rst_n(rst_n), .irq(irq), .host_we(host_we), .host_space(host_space),
    .reg_idx(host_addr[2:0]), .cp_q(cp_q), .err_q(err_q), .srst_busy(srst_busy),
    .srst_wr(srst_wr), .eng_we(eng_we), .td_req_q(td_req_q), .st_q(st_q)
);

// File: tb/ldma_channel_tb_top.sv
module ldma_channel_tb_top;
    import ldma_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_space = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldma_channel #(.RAM_WORDS(64), .CHAN_ID(CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_space(host_space),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct { int due; string req; } exp_t;
    exp_t sb[$];
    exp_t got;
    logic irq_d = 1'b0;

    task automatic chk_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: every irq rise must match the next scoreboard entry's due cycle
    always @(negedge clk) begin
        if (rst_n && irq && !irq_d) begin
            if (sb.size() == 0) begin
                chk_eq("R6", "irq rise with no expected completion", 32'(cyc), 32'hFFFF_FFFF);
            end else begin
                got = sb.pop_front();
                chk_eq(got.req, "irq rise cycle", 32'(cyc), 32'(got.due));
            end
        end
        irq_d <= irq;
    end

    task automatic hwr(input bit sp, input int a, input logic [31:0] d, output int c);
        @(negedge clk);
        host_space = sp; host_addr = a[5:0]; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        c = cyc;
    endtask

    task automatic wr(input bit sp, input int a, input logic [31:0] d);
        int c;
        hwr(sp, a, d, c);
    endtask

    task automatic rd_now(input bit sp, input int a, output logic [31:0] d);
        host_space = sp; host_addr = a[5:0];
        #1 d = host_rdata;
    endtask

    task automatic expect_rd(input string req, input string what, input bit sp, input int a, input logic [31:0] exp);
        logic [31:0] d;
        @(negedge clk);
        rd_now(sp, a, d);
        chk_eq(req, what, d, exp);
    endtask

    task automatic put_desc(input int base, input int nxt, input logic [31:0] mode);
        wr(0, base + W_NEXT, 32'(nxt));
        wr(0, base + W_BUF,  32'(base * 16));
        wr(0, base + W_LEN,  {21'b0, mode[10:0]});
        wr(0, base + W_MODE, mode);
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic push(input int due, input string req);
        exp_t e;
        e.due = due; e.req = req;
        sb.push_back(e);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int c, c2;
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_eq("R1", "irq after reset", {31'b0, irq}, 32'h0);
        expect_rd("R1", "completion ptr", 1, REG_COMPL, 32'h0);
        expect_rd("R1", "head ptr", 1, REG_HEAD, 32'h0);
        expect_rd("R1", "error flag", 1, REG_ERR, 32'h0);
        expect_rd("R1", "soft reset reg", 1, REG_SRST, 32'h0);

        wr(1, REG_CTRL, 32'h1);

        // R2/R3/R4 single descriptor, length 5
        put_desc(4, 0, 32'hE000_0005);
        hwr(1, REG_HEAD, 32'd4, c);
        push(c + 7, "R3");
        wait_cyc(c + 7);
        expect_rd("R3", "cp after single", 1, REG_COMPL, 32'd4);
        expect_rd("R4", "mode single", 0, 4 + W_MODE, 32'hD000_0005);
        expect_rd("R2", "head after end", 1, REG_HEAD, 32'h0);
        wr(1, REG_COMPL, 32'd8);
        chk_eq("R7", "irq after wrong ack", {31'b0, irq}, 32'h1);
        wr(1, REG_COMPL, 32'd4);
        chk_eq("R7", "irq after right ack", {31'b0, irq}, 32'h0);

        // R5 two-descriptor chain
        put_desc(8, 12, 32'hE000_0009);
        put_desc(12, 0, 32'hE000_000A);
        hwr(1, REG_HEAD, 32'd8, c);
        push(c + 11, "R5");
        push(c + 23, "R5");
        wait_cyc(c + 11);
        expect_rd("R5", "cp first link", 1, REG_COMPL, 32'd8);
        wr(1, REG_COMPL, 32'd8);
        wait_cyc(c + 23);
        expect_rd("R5", "cp second link", 1, REG_COMPL, 32'd12);
        expect_rd("R4", "mode first link no EOQ", 0, 8 + W_MODE, 32'hC000_0009);
        expect_rd("R4", "mode last link EOQ", 0, 12 + W_MODE, 32'hD000_000A);
        wr(1, REG_COMPL, 32'd12);

        // R3 zero length
        put_desc(16, 0, 32'hE000_0000);
        hwr(1, REG_HEAD, 32'd16, c);
        push(c + 2, "R3");
        wait_cyc(c + 2);
        expect_rd("R3", "mode zero length", 0, 16 + W_MODE, 32'hD000_0000);
        wr(1, REG_COMPL, 32'd16);

        // R6 descriptor not owned
        put_desc(20, 0, 32'hC000_0006);
        hwr(1, REG_HEAD, 32'd20, c);
        wait_cyc(c + 10);
        chk_eq("R6", "irq not owned", {31'b0, irq}, 32'h0);
        expect_rd("R6", "mode not owned", 0, 20 + W_MODE, 32'hC000_0006);
        expect_rd("R6", "head not owned", 1, REG_HEAD, 32'h0);

        // R8 head write while busy
        put_desc(28, 0, 32'hE000_0003);
        put_desc(24, 0, 32'hE000_0014);
        hwr(1, REG_HEAD, 32'd24, c);
        push(c + 22, "R8");
        wr(1, REG_HEAD, 32'd28);
        expect_rd("R8", "error flag set", 1, REG_ERR, 32'h1);
        wait_cyc(c + 22);
        expect_rd("R8", "cp busy case", 1, REG_COMPL, 32'd24);
        expect_rd("R8", "ignored descriptor untouched", 0, 28 + W_MODE, 32'hE000_0003);
        wr(1, REG_COMPL, 32'd24);
        wait_cyc(c + 30);
        expect_rd("R8", "error flag sticky", 1, REG_ERR, 32'h1);

        // R9 teardown mid-transfer
        put_desc(32, 36, 32'hE000_001E);
        put_desc(36, 0, 32'hE000_0004);
        hwr(1, REG_HEAD, 32'd32, c);
        wr(1, REG_TDOWN, 32'(CH + 1));
        hwr(1, REG_TDOWN, 32'(CH), c2);
        push(c2 + 2, "R9");
        wait_cyc(c2 + 2);
        expect_rd("R9", "cp teardown magic", 1, REG_COMPL, TD_MAGIC);
        expect_rd("R9", "mode torn down", 0, 32 + W_MODE, 32'hC800_001E);
        expect_rd("R9", "next link untouched", 0, 36 + W_MODE, 32'hE000_0004);
        expect_rd("R9", "head after teardown", 1, REG_HEAD, 32'h0);
        wr(1, REG_COMPL, TD_MAGIC);
        chk_eq("R9", "irq after teardown ack", {31'b0, irq}, 32'h0);

        // R10 disabled hold, then enable
        wr(1, REG_CTRL, 32'h0);
        put_desc(40, 0, 32'hE000_0003);
        hwr(1, REG_HEAD, 32'd40, c);
        wait_cyc(c + 8);
        chk_eq("R10", "irq while disabled", {31'b0, irq}, 32'h0);
        expect_rd("R10", "mode while disabled", 0, 40 + W_MODE, 32'hE000_0003);
        expect_rd("R10", "head held", 1, REG_HEAD, 32'd40);
        hwr(1, REG_CTRL, 32'h1, c);
        push(c + 6, "R10");
        wait_cyc(c + 6);
        expect_rd("R10", "mode after enable", 0, 40 + W_MODE, 32'hD000_0003);
        wr(1, REG_COMPL, 32'd40);

        // R12 restart after end of queue
        put_desc(44, 0, 32'hE000_0002);
        wr(0, 40 + W_NEXT, 32'd44);
        hwr(1, REG_HEAD, 32'd44, c);
        push(c + 4, "R12");
        wait_cyc(c + 4);
        expect_rd("R12", "cp restart", 1, REG_COMPL, 32'd44);
        expect_rd("R12", "mode restart", 0, 44 + W_MODE, 32'hD000_0002);

        // R11 soft reset with irq still pending
        hwr(1, REG_SRST, 32'h1, c);
        rd_now(1, REG_SRST, d);
        chk_eq("R11", "soft reset busy readback", d, 32'h1);
        expect_rd("R11", "soft reset done", 1, REG_SRST, 32'h0);
        expect_rd("R11", "cp cleared", 1, REG_COMPL, 32'h0);
        expect_rd("R11", "head cleared", 1, REG_HEAD, 32'h0);
        expect_rd("R11", "error cleared", 1, REG_ERR, 32'h0);
        chk_eq("R11", "irq cleared", {31'b0, irq}, 32'h0);

        repeat (5) @(negedge clk);
        chk_eq("R3", "outstanding expected completions", 32'(sb.size()), 32'h0);
        done = 1;
        finish_run();
    end
endmodule